// File: doc/BRIEF.md
# Endian-Selectable Long-Word Unpacker

This block sits on the read side of a long-word FIFO and feeds a port that may be narrower than the stored word. The FIFO always holds whole long words of four 9-bit lanes (36 bits by default). The block hands each word to the port in one of three ways, picked by a static size select: as one long word, as two half words, or as four single lanes. It pulls a word from the FIFO on the first read of that word. The portions not yet delivered wait in a holding register and come out on the reads that follow.

The delivery order is chosen at reset. In big-endian order the most significant portion comes first. In little-endian order the least significant portion comes first. The size select and the endian select are both sampled while reset is asserted. The values present at the last clock edge before release stay in force until the next reset, and later changes on those pins have no effect.

The FIFO is a show-ahead FIFO. Its head word is visible on `fifo_data` whenever `fifo_empty` is low, and asserting `fifo_pop` for one cycle removes that word.

Top module: `rd_unpacker`

## Requirements
- R1: While reset is asserted, and on the first cycle after release, no portion is buffered. `rd_empty` then equals `fifo_empty` and `fifo_pop` is low.
- R2: With size select 2'b00 (full width), every accepted read delivers the whole FIFO head word on `rd_data` and pops the FIFO in the same cycle. The endian select has no effect in this mode.
- R3: With size select 2'b01 (half width) and big-endian order, a word W is delivered on two reads: W[35:18] first, then W[17:0]. Each half is placed on `rd_data[17:0]`.
- R4: With size select 2'b01 and little-endian order, W[17:0] is delivered first and W[35:18] second.
- R5: With size select 2'b10 or 2'b11 (lane width) and big-endian order, a word is delivered as W[35:27], W[26:18], W[17:9], W[8:0], each on `rd_data[8:0]`.
- R6: With lane width and little-endian order, the lanes come out in the order W[8:0], W[17:9], W[26:18], W[35:27].
- R7: `fifo_pop` is high only in a cycle where `rd_en` is high, the FIFO is not empty and no portion of an earlier word is still buffered. A word is therefore popped exactly once, on the read that delivers its first portion.
- R8: `rd_empty` is high exactly when the FIFO is empty and no portion is buffered. While `rd_empty` is high, `rd_data` is zero and `rd_en` changes no state.
- R9: Changes on `size_sel` or `big_end` after reset release do not change the size or the order of the portions delivered.
- R10: In half-width mode `rd_data[35:18]` is zero. In lane-width mode `rd_data[35:9]` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is sampled while it is low |
| size_sel | input | 2 | Port width: 00 full, 01 half, 1x lane |
| big_end | input | 1 | 1 selects most-significant-portion-first order |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_data | input | 36 | FIFO head word (show-ahead) |
| fifo_pop | output | 1 | Removes the FIFO head word at this clock edge |
| rd_en | input | 1 | Port read request |
| rd_data | output | 36 | Current portion, placed at the low end of the bus |
| rd_empty | output | 1 | No portion is available to read |

## Verification
The read sequence runs under all five combinations of width and order on distinct, asymmetric words, so that a swapped half, a swapped lane or a shifted lane index shows up as a wrong value. Reads are issued both back to back and with idle gaps. New words are also pushed while a word is only partly delivered, which separates popping at the wrap from popping on every read. Reads against an empty source check that nothing is consumed. Toggling the configuration pins in mid-stream shows whether the order and width come from the latched values or from the live pins.

// File: rtl/rd_unpacker.sv
module rd_unpacker #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              size_sel,
  input  logic                    big_end,
  input  logic                    fifo_empty,
  input  logic [LANE_W*LANES-1:0] fifo_data,
  output logic                    fifo_pop,
  input  logic                    rd_en,
  output logic [LANE_W*LANES-1:0] rd_data,
  output logic                    rd_empty
);
  localparam int LW   = LANE_W * LANES;
  localparam int HW   = LW / 2;
  localparam int PH_W = $clog2(LANES);

  logic [1:0]      sz_q;
  logic            be_q;
  logic [PH_W-1:0] ph;
  logic [LW-1:0]   hold;
  logic [LW-1:0]   src;
  logic [PH_W-1:0] last_ph;
  logic [PH_W-1:0] idx;
  logic            take;

  // portion count minus one for the latched width
  always_comb begin
    if (sz_q[1])           last_ph = PH_W'(LANES - 1);
    else if (sz_q == 2'b01) last_ph = PH_W'(1);
    else                   last_ph = '0;
  end

  assign idx      = be_q ? (last_ph - ph) : ph;
  assign src      = (ph == '0) ? fifo_data : hold;
  assign rd_empty = (ph == '0) && fifo_empty;
  assign take     = rd_en && !rd_empty;
  assign fifo_pop = take && (ph == '0);

  always_comb begin
    rd_data = '0;
    if (!rd_empty) begin
      if (sz_q[1])
        rd_data[LANE_W-1:0] = src[idx*LANE_W +: LANE_W];
      else if (sz_q == 2'b01)
        rd_data[HW-1:0] = idx[0] ? src[LW-1:HW] : src[HW-1:0];
      else
        rd_data = src;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sz_q <= size_sel;
      be_q <= big_end;
      ph   <= '0;
      hold <= '0;
    end else if (take) begin
      if (ph == '0) hold <= fifo_data;
      ph <= (ph == last_ph) ? '0 : ph + 1'b1;
    end
  end
endmodule

module rd_unpacker_chk #(
  parameter int LW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_empty,
  input logic          fifo_pop,
  input logic          rd_en,
  input logic          rd_empty,
  input logic [LW-1:0] rd_data,
  input logic [1:0]    sz_q,
  input logic          be_q
);
  // R7
  pop_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (rd_en && !fifo_empty));
  // R8
  empty_needs_src_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |-> fifo_empty);
  // R8
  empty_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |-> (rd_data == '0));
  // R2
  full_width_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sz_q == 2'b00 && rd_en && !rd_empty) |-> fifo_pop);
  // R3
  narrow_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop && sz_q != 2'b00) |=> (!rd_empty && !fifo_pop));
  // R10
  lane_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sz_q[1] |-> (rd_data[LW-1:9] == '0));
  // R9
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($stable(sz_q) && $stable(be_q)));
endmodule

bind rd_unpacker rd_unpacker_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
  .rd_en(rd_en), .rd_empty(rd_empty), .rd_data(rd_data),
  .sz_q(sz_q), .be_q(be_q)
);

// File: tb/sim_rd_unpacker.sv
`timescale 1ns/1ps
module sim_rd_unpacker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'b00;
  logic        big_end = 1'b0;
  logic        fifo_empty = 1'b1;
  logic [35:0] fifo_data = '0;
  logic        fifo_pop;
  logic        rd_en = 1'b0;
  logic [35:0] rd_data;
  logic        rd_empty;

  int checks = 0;
  int errors = 0;
  bit pend = 0;
  bit done = 0;
  logic [1:0] cur_sz = 2'b00;
  logic       cur_be = 1'b0;

  logic [35:0] fq[$];
  logic [35:0] exp_d[$];
  bit          exp_first[$];
  string       exp_tag[$];

  always #2.5 clk = ~clk;

  rd_unpacker u0 (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .big_end(big_end),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    fifo_empty = (fq.size() == 0);
    fifo_data  = fifo_empty ? 36'h0 : fq[0];
  endtask

  // FIFO model: pop after the edge that consumed the head
  always begin
    @(posedge clk);
    #1;
    if (pend && fq.size() > 0) void'(fq.pop_front());
    pend = 0;
    refresh();
  end

  function automatic string mode_tag(input logic [1:0] s, input logic b);
    if (s == 2'b00) return "R2";
    if (s == 2'b01) return b ? "R3" : "R4";
    return b ? "R5" : "R6";
  endfunction

  // driver: load a word and its expected portions
  task automatic push_word(input logic [35:0] w);
    int n;
    n = (cur_sz == 2'b00) ? 1 : (cur_sz == 2'b01) ? 2 : 4;
    fq.push_back(w);
    refresh();
    for (int i = 0; i < n; i++) begin
      int k;
      logic [35:0] e;
      k = cur_be ? (n - 1 - i) : i;
      e = '0;
      if (n == 1) e = w;
      else if (n == 2) e[17:0] = w[k*18 +: 18];
      else e[8:0] = w[k*9 +: 9];
      exp_d.push_back(e);
      exp_first.push_back(i == 0);
      exp_tag.push_back(mode_tag(cur_sz, cur_be));
    end
  endtask

  // monitor: compare mid-cycle against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (!rd_empty) begin
        if (exp_d.size() == 0) begin
          check(0, "R8 unexpected read", rd_data, 36'h0);
        end else begin
          logic [35:0] e;
          bit f;
          string t;
          e = exp_d.pop_front();
          f = exp_first.pop_front();
          t = exp_tag.pop_front();
          check(rd_data === e, {t, " R10 data"}, rd_data, e);
          check(fifo_pop === f, "R7 pop on first portion", {35'h0, fifo_pop}, {35'h0, f});
          pend = fifo_pop;
        end
      end else begin
        check(rd_data === 36'h0 && fifo_pop === 1'b0, "R8 empty read ignored",
              rd_data, 36'h0);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic [1:0] s, input logic b);
    rst_n = 1'b0;
    size_sel = s;
    big_end = b;
    cur_sz = s;
    cur_be = b;
    repeat (3) step();
    check(rd_empty === 1'b1 && fifo_pop === 1'b0, "R1 in reset",
          {34'h0, rd_empty, fifo_pop}, 36'h2);
    rst_n = 1'b1;
    step();
    check(rd_empty === fifo_empty && fifo_pop === 1'b0, "R1 after release",
          {34'h0, rd_empty, fifo_pop}, {34'h0, fifo_empty, 1'b0});
  endtask

  task automatic read_n(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic drain_check(input string tag);
    step();
    check(exp_d.size() == 0, {tag, " all portions delivered"}, 36'(exp_d.size()), 36'h0);
    check(rd_empty === 1'b1, {"R8 empty after ", tag}, {35'h0, rd_empty}, 36'h1);
  endtask

  task automatic run_mode(input logic [1:0] s, input logic b, input int gap);
    int n;
    do_reset(s, b);
    n = (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    push_word(36'h9_A5C3_1E7B);
    push_word(36'h1_2345_6789);
    push_word(36'hF_0F0F_0F0F);
    read_n(3 * n, gap);
    drain_check(mode_tag(s, b));
  endtask

  initial begin
    refresh();
    run_mode(2'b00, 1'b1, 0);
    run_mode(2'b00, 1'b0, 1);
    run_mode(2'b01, 1'b1, 0);
    run_mode(2'b01, 1'b0, 2);
    run_mode(2'b10, 1'b1, 1);
    run_mode(2'b11, 1'b0, 0);

    // R8: reads against an empty source change nothing
    do_reset(2'b10, 1'b1);
    read_n(3, 0);
    push_word(36'h8_7654_3210);
    read_n(4, 0);
    drain_check("R8");

    // R7: word arrives while previous one only partly delivered
    do_reset(2'b10, 1'b0);
    push_word(36'h3_C0DE_BEEF);
    read_n(2, 0);
    push_word(36'hA_BCDE_F012);
    read_n(6, 1);
    drain_check("R7");

    // R9: pins toggled after release are ignored
    do_reset(2'b01, 1'b1);
    push_word(36'h5_5AA5_33CC);
    read_n(1, 0);
    size_sel = 2'b00;
    big_end = 1'b0;
    push_word(36'h6_1122_3344);
    read_n(3, 0);
    size_sel = 2'b10;
    read_n(0, 0);
    drain_check("R9");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule